// File: doc/BRIEF.md
# Level-Sensitive Interrupt Controller with Banked Masks

The block gathers a set of level-sensitive interrupt request lines (96 by default, organised as banks of 32) and presents a single interrupt request to a processor. Software reaches it through a plain 32-bit register port with a byte address, a write strobe and a combinational read path. Every line carries a mask bit. The mask bits of each bank are changed only through two write-only-style addresses: one that masks the lines whose data bits are 1 and one that unmasks them. Both addresses read back the current mask word of their bank.

When no interrupt is held and at least one unmasked line is high, the lowest-numbered such line is captured into an active-number register, and the processor interrupt is raised. The capture is frozen until software writes the acknowledge bit. The usual service flow masks the line first and acknowledges it second, so a line that stays high cannot fire again until it is unmasked. A self-timed soft reset returns the mask and capture state to their power-on values. A status bit shows when the soft reset has finished. A revision register and one stored idle-enable flag complete the register set.

Top module: `irq_hub`

## Requirements
- R1: After the reset input, every mask bit is 1 (all lines masked), irq_out is 0, the idle flag reads 0, and the status register at 0x14 reads 1.
- R2: A write to the mask-set address of bank b (0x8C + 0x20*b) sets mask bit n of that bank for each data bit n that is 1. Zero bits leave their mask bits unchanged. Reading the set or the clear address of bank b returns that bank's mask word.
- R3: A write to the mask-clear address of bank b (0x88 + 0x20*b) clears mask bit n for each data bit n that is 1, which unmasks line 32*b+n. Zero bits have no effect.
- R4: When no interrupt is held and one or more lines are both high and unmasked, the lowest such line number is captured at the next clock edge. The register at 0x40 then reads bit 31 = 1 and bits 6:0 = line number. irq_out equals this held bit.
- R5: A held capture does not change when lines or masks change. A write to 0x48 with data bit 0 = 1 drops it at the next edge, and a new line can be captured one edge later. A write to 0x48 with bit 0 = 0 has no effect.
- R6: A line whose mask bit is 1 is never captured. A line that is unmasked and still high after an acknowledge is captured again.
- R7: Writing 0x10 with bit 1 = 1 starts a soft reset that lasts 4 cycles. During those cycles 0x10 bit 1 reads 1, 0x14 bit 0 reads 0, all mask bits are forced to 1, the capture is dropped, irq_out is 0, and mask writes are ignored. Afterwards 0x10 bit 1 reads 0 and 0x14 bit 0 reads 1.
- R8: Bit 0 of 0x10 is an idle-enable flag. It takes data bit 0 of every write to 0x10 and reads back unchanged.
- R9: Address 0x00 reads the revision: major number in bits 7:4, minor number in bits 3:0, other bits 0. The default is 0x21.
- R10: Reads of any address not listed above return 0, and writes to such addresses change no readable state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_lines | input | 96 | Level-sensitive interrupt request lines, bit i = line i |
| bus_wr | input | 1 | Write strobe for the register port, one write per cycle |
| bus_addr | input | 12 | Byte address of the register access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq_out | output | 1 | Interrupt request to the processor |

## Verification
The bench builds the block with its defaults: three banks, a four-cycle soft reset and revision 2.1. With three banks, the bank-address stride (0x88, 0xA8, 0xC8 and their set partners) is exercised, and lines in the top bank up to 95 are reached. It also shows that the lowest-number rule works across bank boundaries and not only inside one word. The four-cycle soft reset is short enough that a random phase often lands mask writes, acknowledges and second soft-reset requests inside the busy window. The reference model is compared against the design on every one of those cycles.

// File: rtl/irq_hub_pkg.sv
package irq_hub_pkg;
    localparam int ADDR_W      = 12;
    localparam int BANK_W      = 32;
    localparam int BANK_STRIDE = 32;

    localparam logic [ADDR_W-1:0] OFS_REV    = 12'h000;
    localparam logic [ADDR_W-1:0] OFS_SYSCFG = 12'h010;
    localparam logic [ADDR_W-1:0] OFS_STATUS = 12'h014;
    localparam logic [ADDR_W-1:0] OFS_ACTIVE = 12'h040;
    localparam logic [ADDR_W-1:0] OFS_CTRL   = 12'h048;
    localparam logic [ADDR_W-1:0] OFS_MCLR0  = 12'h088;
    localparam logic [ADDR_W-1:0] OFS_MSET0  = 12'h08C;

    localparam int CFG_IDLE_BIT = 0;
    localparam int CFG_SRST_BIT = 1;

    function automatic logic [ADDR_W-1:0] bank_clr_addr(input int b);
        return OFS_MCLR0 + ADDR_W'(b * BANK_STRIDE);
    endfunction

    function automatic logic [ADDR_W-1:0] bank_set_addr(input int b);
        return OFS_MSET0 + ADDR_W'(b * BANK_STRIDE);
    endfunction
endpackage

// File: rtl/irq_hub_prio.sv
module irq_hub_prio #(
    parameter int N     = 96,
    parameter int IDX_W = $clog2(N)
) (
    input  logic [N-1:0]     req,
    output logic             found,
    output logic [IDX_W-1:0] idx
);
    always_comb begin
        found = |req;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                idx = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/irq_hub_srst.sv
module irq_hub_srst #(
    parameter int CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy
);
    localparam int CNT_W = (CYCLES < 2) ? 1 : $clog2(CYCLES);

    typedef struct packed {
        logic             busy;
        logic [CNT_W-1:0] cnt;
    } srst_t;

    srst_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.busy) begin
            if (st_q.cnt == '0) begin
                st_d.busy = 1'b0;
            end else begin
                st_d.cnt = st_q.cnt - CNT_W'(1);
            end
        end else if (start) begin
            st_d.busy = 1'b1;
            st_d.cnt  = CNT_W'(CYCLES - 1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy = st_q.busy;
endmodule

// File: rtl/irq_hub.sv
module irq_hub
    import irq_hub_pkg::*;
#(
    parameter int NUM_BANKS   = 3,
    parameter int REV_MAJOR   = 2,
    parameter int REV_MINOR   = 1,
    parameter int SRST_CYCLES = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NUM_BANKS*BANK_W-1:0] irq_lines,
    input  logic                        bus_wr,
    input  logic [ADDR_W-1:0]           bus_addr,
    input  logic [31:0]                 bus_wdata,
    output logic [31:0]                 bus_rdata,
    output logic                        irq_out
);
    localparam int LINES = NUM_BANKS * BANK_W;
    localparam int IDX_W = $clog2(LINES);

    typedef struct packed {
        logic [NUM_BANKS-1:0][BANK_W-1:0] mask;
        logic                             valid;
        logic [IDX_W-1:0]                 num;
        logic                             idle_en;
    } hub_t;

    hub_t st_d, st_q;

    logic [LINES-1:0] mask_flat;
    logic [LINES-1:0] pend;
    logic             found;
    logic [IDX_W-1:0] winner;
    logic             srst_busy;
    logic             cfg_hit;
    logic             srst_start;
    logic             ack_hit;
    logic             act_valid;
    logic [IDX_W-1:0] act_num;

    assign mask_flat = st_q.mask;

    // A line is requesting when it is high and its mask bit is 0.
    for (genvar gb = 0; gb < NUM_BANKS; gb++) begin : g_bank
        assign pend[gb*BANK_W +: BANK_W] = irq_lines[gb*BANK_W +: BANK_W] & ~st_q.mask[gb];
    end

    irq_hub_prio #(
        .N     (LINES),
        .IDX_W (IDX_W)
    ) i_prio (
        .req   (pend),
        .found (found),
        .idx   (winner)
    );

    assign cfg_hit    = bus_wr && (bus_addr == OFS_SYSCFG);
    assign srst_start = cfg_hit && bus_wdata[CFG_SRST_BIT];
    assign ack_hit    = bus_wr && (bus_addr == OFS_CTRL) && bus_wdata[0];

    irq_hub_srst #(
        .CYCLES (SRST_CYCLES)
    ) i_srst (
        .clk   (clk),
        .rst_n (rst_n),
        .start (srst_start),
        .busy  (srst_busy)
    );

    always_comb begin
        st_d = st_q;
        if (cfg_hit) begin
            st_d.idle_en = bus_wdata[CFG_IDLE_BIT];
        end
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (bus_wr && (bus_addr == bank_clr_addr(b))) begin
                st_d.mask[b] = st_q.mask[b] & ~bus_wdata;
            end
            if (bus_wr && (bus_addr == bank_set_addr(b))) begin
                st_d.mask[b] = st_q.mask[b] | bus_wdata;
            end
        end
        // Capture only into an empty slot; the held number is frozen otherwise.
        if (!st_q.valid && found && !srst_busy) begin
            st_d.valid = 1'b1;
            st_d.num   = winner;
        end
        if (ack_hit) begin
            st_d.valid = 1'b0;
        end
        // Soft reset owns the mask and capture state for its whole window.
        if (srst_start || srst_busy) begin
            st_d.mask  = '1;
            st_d.valid = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q         <= '0;
            st_q.mask    <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            OFS_REV:    bus_rdata = {24'd0, 4'(REV_MAJOR), 4'(REV_MINOR)};
            OFS_SYSCFG: bus_rdata = {30'd0, srst_busy, st_q.idle_en};
            OFS_STATUS: bus_rdata = {31'd0, !srst_busy};
            OFS_ACTIVE: bus_rdata = {st_q.valid, {(31-IDX_W){1'b0}}, st_q.num};
            default:    bus_rdata = '0;
        endcase
        for (int b = 0; b < NUM_BANKS; b++) begin
            if ((bus_addr == bank_clr_addr(b)) || (bus_addr == bank_set_addr(b))) begin
                bus_rdata = st_q.mask[b];
            end
        end
    end

    assign act_valid = st_q.valid;
    assign act_num   = st_q.num;
    assign irq_out   = st_q.valid;
endmodule

// File: rtl/irq_hub_chk.sv
module irq_hub_chk
    import irq_hub_pkg::*;
#(
    parameter int LINES = 96,
    parameter int IDX_W = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_wdata,
    input logic              irq_out,
    input logic              busy,
    input logic              act_valid,
    input logic [IDX_W-1:0]  act_num,
    input logic [LINES-1:0]  pend,
    input logic [LINES-1:0]  mask_flat
);
    p_set_bank0_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == OFS_MSET0 && !busy)
        |=> ((mask_flat[31:0] & $past(bus_wdata)) == $past(bus_wdata)));

    p_clr_bank0_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == OFS_MCLR0 && !busy)
        |=> ((mask_flat[31:0] & $past(bus_wdata)) == 32'd0));

    p_lowest_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(act_valid)
        |-> (((($past(pend) >> act_num) & LINES'(1)) == LINES'(1))
             && (($past(pend) & ((LINES'(1) << act_num) - LINES'(1))) == '0)));

    p_ack_drops_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == OFS_CTRL && bus_wdata[0]) |=> !irq_out);

    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (act_valid && !busy
         && !(bus_wr && bus_addr == OFS_CTRL && bus_wdata[0])
         && !(bus_wr && bus_addr == OFS_SYSCFG && bus_wdata[CFG_SRST_BIT]))
        |=> (act_valid && $stable(act_num)));

    p_srst_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (!irq_out && (mask_flat == '1)));
endmodule

bind irq_hub irq_hub_chk #(
    .LINES (LINES),
    .IDX_W (IDX_W)
) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .irq_out   (irq_out),
    .busy      (srst_busy),
    .act_valid (act_valid),
    .act_num   (act_num),
    .pend      (pend),
    .mask_flat (mask_flat)
);

// File: tb/test_irq_hub.sv
`timescale 1ns/1ps
module test_irq_hub;
    localparam int NB    = 3;
    localparam int LINES = NB * 32;
    localparam int SRSTN = 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [LINES-1:0] irq_lines = '0;
    logic             bus_wr = 1'b0;
    logic [11:0]      bus_addr = '0;
    logic [31:0]      bus_wdata = '0;
    logic [31:0]      bus_rdata;
    logic             irq_out;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    irq_hub i_irq_hub (
        .clk       (clk),
        .rst_n     (rst_n),
        .irq_lines (irq_lines),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_out   (irq_out)
    );

    // Behavioural reference model
    bit [LINES-1:0] m_mask = '1;
    bit             m_valid = 0;
    int             m_num = 0;
    int             m_cnt = 0;
    bit             m_idle = 0;

    always @(posedge clk) begin : model
        bit [LINES-1:0] nmask;
        bit nvalid, nidle, busy, start;
        int nnum, ncnt;
        if (!rst_n) begin
            m_mask = '1; m_valid = 0; m_num = 0; m_cnt = 0; m_idle = 0;
        end else begin
            nmask = m_mask; nvalid = m_valid; nnum = m_num; ncnt = m_cnt; nidle = m_idle;
            busy  = (m_cnt > 0);
            start = bus_wr && bus_addr == 12'h010 && bus_wdata[1] && !busy;
            if (bus_wr && bus_addr == 12'h010) nidle = bus_wdata[0];
            for (int b = 0; b < NB; b++) begin
                for (int k = 0; k < 32; k++) begin
                    if (bus_wr && bus_addr == 12'h088 + 32*b && bus_wdata[k]) nmask[32*b+k] = 0;
                    if (bus_wr && bus_addr == 12'h08C + 32*b && bus_wdata[k]) nmask[32*b+k] = 1;
                end
            end
            if (!m_valid && !busy) begin
                for (int i = 0; i < LINES; i++) begin
                    if (!nvalid && irq_lines[i] && !m_mask[i]) begin
                        nvalid = 1; nnum = i;
                    end
                end
            end
            if (bus_wr && bus_addr == 12'h048 && bus_wdata[0]) nvalid = 0;
            if (start || busy) begin
                nmask = '1; nvalid = 0;
            end
            if (start) ncnt = SRSTN;
            else if (m_cnt > 0) ncnt = m_cnt - 1;
            m_mask = nmask; m_valid = nvalid; m_num = nnum; m_cnt = ncnt; m_idle = nidle;
        end
    end

    function automatic logic [31:0] exp_rd(input logic [11:0] a);
        logic [31:0] r;
        r = 0;
        case (a)
            12'h000: r = 32'h21;
            12'h010: r = {30'd0, m_cnt > 0, m_idle};
            12'h014: r = {31'd0, m_cnt == 0};
            12'h040: r = {m_valid, 24'd0, 7'(m_num)};
            default: r = 0;
        endcase
        for (int b = 0; b < NB; b++)
            if (a == 12'h088 + 32*b || a == 12'h08C + 32*b) r = m_mask[32*b +: 32];
        return r;
    endfunction

    function automatic string tag_of(input logic [11:0] a);
        if (a == 12'h000) return "R9";
        if (a == 12'h010) return "R8";
        if (a == 12'h014) return "R7";
        if (a == 12'h040) return "R4";
        for (int b = 0; b < NB; b++)
            if (a == 12'h088 + 32*b || a == 12'h08C + 32*b) return "R2";
        return "R10";
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h at %0t", req, act, exp, $time);
        end
    endtask

    // Cycle-by-cycle comparison against the model, mid low phase
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            #5;
            chk("R4 irq_out", {31'd0, irq_out}, {31'd0, m_valid});
            chk(tag_of(bus_addr), bus_rdata, exp_rd(bus_addr));
        end
    end

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        bus_wr = 0; bus_addr = a;
        #6;
        d = bus_rdata;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic finish_run;
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin : watchdog
        #(200000 * 20);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin : main
        logic [31:0] d;
        logic [31:0] lf;
        idle(3);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state, R9, R10
        rd(12'h088, d); chk("R1 mask bank0", d, 32'hFFFF_FFFF);
        rd(12'h0CC, d); chk("R1 mask bank2", d, 32'hFFFF_FFFF);
        rd(12'h014, d); chk("R1 status", d, 32'h1);
        rd(12'h010, d); chk("R1 idle flag", d, 32'h0);
        chk("R1 irq_out", {31'd0, irq_out}, 32'h0);
        rd(12'h000, d); chk("R9 revision", d, 32'h21);
        rd(12'h004, d); chk("R10 unimplemented read", d, 32'h0);
        // R6 masked lines ignored
        irq_lines[5] = 1; irq_lines[40] = 1; irq_lines[90] = 1;
        idle(3);
        chk("R6 masked no irq", {31'd0, irq_out}, 32'h0);
        // R3 unmask 40 and 90; R4 lowest across banks
        wr(12'h0A8, 32'h0000_0100);
        wr(12'h0C8, 32'h0400_0000);
        rd(12'h0A8, d); chk("R3 bank1 clear", d, 32'hFFFF_FEFF);
        idle(1);
        rd(12'h040, d); chk("R4 active 40", d, 32'h8000_0028);
        chk("R4 irq_out high", {31'd0, irq_out}, 32'h1);
        // R5 hold while lower line unmasked, ack with bit0=0 ignored
        wr(12'h088, 32'h0000_0020);
        wr(12'h048, 32'h0000_0000);
        idle(1);
        rd(12'h040, d); chk("R5 hold", d, 32'h8000_0028);
        wr(12'h048, 32'h1);
        rd(12'h040, d); chk("R5 ack drops", d, 32'h0000_0028);
        idle(1);
        rd(12'h040, d); chk("R4 lowest 5", d, 32'h8000_0005);
        // R6 mask then ack flow
        wr(12'h08C, 32'h0000_0020); wr(12'h048, 32'h1); idle(1);
        rd(12'h040, d); chk("R6 relatch 40", d, 32'h8000_0028);
        wr(12'h0AC, 32'h0000_0100); wr(12'h048, 32'h1); idle(1);
        rd(12'h040, d); chk("R6 relatch 90", d, 32'h8000_005A);
        wr(12'h0CC, 32'h0400_0000); wr(12'h048, 32'h1); idle(2);
        chk("R6 all masked quiet", {31'd0, irq_out}, 32'h0);
        rd(12'h0AC, d); chk("R2 bank1 set back", d, 32'hFFFF_FFFF);
        // R10 write to unimplemented address
        wr(12'h090, 32'hFFFF_FFFF);
        rd(12'h090, d); chk("R10 write ignored read", d, 32'h0);
        rd(12'h088, d); chk("R10 masks unchanged", d, 32'hFFFF_FFFF);
        // R8 idle flag
        wr(12'h010, 32'h1);
        rd(12'h010, d); chk("R8 idle set", d, 32'h1);
        // R7 soft reset
        wr(12'h088, 32'h0000_0020); idle(1);
        chk("R7 pre irq", {31'd0, irq_out}, 32'h1);
        wr(12'h010, 32'h2);
        rd(12'h010, d); chk("R7 busy bit", d, 32'h2);
        rd(12'h014, d); chk("R7 status low", d, 32'h0);
        chk("R7 irq dropped", {31'd0, irq_out}, 32'h0);
        wr(12'h088, 32'hFFFF_FFFF);
        rd(12'h088, d); chk("R7 mask write ignored", d, 32'hFFFF_FFFF);
        idle(3);
        rd(12'h010, d); chk("R7 busy done", d, 32'h0);
        rd(12'h014, d); chk("R7 status high", d, 32'h1);
        rd(12'h088, d); chk("R7 masks restored", d, 32'hFFFF_FFFF);
        // Random phase compared against the model every cycle
        lf = 32'hACE1_1234;
        for (int c = 0; c < 3000; c++) begin
            @(negedge clk);
            lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
            irq_lines = {lf, {lf[15:0], lf[31:16]}, ~lf} & {lf[7:0], lf[31:8], lf, lf[3:0], lf[31:4]};
            bus_wr = 0;
            bus_wdata = {lf[0], lf[31:1]};
            case (lf[3:0])
                4'd0: begin bus_wr = 1; bus_addr = 12'h048; bus_wdata[0] = lf[4]; end
                4'd1, 4'd2: begin bus_wr = 1; bus_addr = 12'h088 + 12'(32 * (lf[9:8] % 3)); end
                4'd3: begin bus_wr = 1; bus_addr = 12'h08C + 12'(32 * (lf[9:8] % 3)); end
                4'd4: begin bus_wr = 1; bus_addr = 12'h010;
                            bus_wdata[1] = (lf[7:4] == 4'd0); end
                4'd5: begin bus_wr = 1; bus_addr = 12'h040; end
                default: begin
                    case (lf[6:4])
                        3'd0: bus_addr = 12'h000;
                        3'd1: bus_addr = 12'h010;
                        3'd2: bus_addr = 12'h014;
                        3'd3, 3'd4: bus_addr = 12'h040;
                        3'd5: bus_addr = 12'h0A8;
                        3'd6: bus_addr = 12'h0CC;
                        default: bus_addr = 12'h0E0;
                    endcase
                end
            endcase
        end
        @(negedge clk);
        bus_wr = 0;
        idle(2);
        finish_run();
    end
endmodule